// File: doc/BRIEF.md
# Prioritized Interrupt Level Evaluator

This block folds two request sources into one interrupt request level. A software request register covers bit positions 4 to 18, and a vector of external request lines covers positions 20 to 30. Both sources share one 5-bit level space, but each uses its own offset rule. The block also builds a summary mask with one bit for every pending request. When the level is nonzero and above a programmable current priority level, the block issues a one-cycle trap request. In that same cycle it stores the summary in a status register and the level in an identifier register.

Evaluation is not continuous. A check-request pulse, such as a return from an exception handler, arms the evaluator. The evaluator then makes one decision on the next clock edge and disarms itself. An asynchronous-trap request register is also kept, but it is not serviced. When it holds a nonzero value, the block raises an error flag.

A single write port loads three registers, and `cfg_sel` picks which one. The value 0 selects the priority level, 1 selects the software requests, 2 selects the asynchronous-trap request, and 3 writes nothing.

Top module: `irq_level_eval`

## Requirements
- R1: A set software request bit at position i (4 to 18) gives request level i - 3, so bit 4 is level 1 and bit 18 is level 15.
- R2: A set external line at position i (20 to 30) gives request level i. Lines outside that range give no level.
- R3: When several requests are pending, the highest pending position decides the level. Any in-range external line therefore outranks every software bit.
- R4: The summary mask has a 1 at the position of every pending in-range software bit and external line, and 0 everywhere else.
- R5: A trap is raised only when the level is nonzero and strictly greater than the priority level register. A level equal to the priority level raises no trap.
- R6: A trap is a `trap_o` pulse lasting exactly one cycle. It appears in the cycle after the evaluating clock edge, together with the newly loaded status (`isr_o`) and identifier (`intid_o`). An evaluation without a trap leaves both `isr_o` and `intid_o` unchanged.
- R7: A write with `cfg_sel` = 0 keeps only the low 5 bits of the data as the priority level.
- R8: A write with `cfg_sel` = 1 keeps only bits 4 to 18 of the data (mask 0x0007FFF0) as the software requests.
- R9: The evaluator is armed out of reset and by `eret_i`. Each evaluation disarms it. A check request that arrives on the same edge as an evaluation keeps it armed for one more evaluation.
- R10: A write with `cfg_sel` = 2 keeps only the low 4 bits as the asynchronous-trap request. `ast_err_o` is high exactly while that value is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 priority level, 1 software requests, 2 async-trap request |
| cfg_wdata | input | 32 | Write data |
| ext_irq | input | 32 | External request lines |
| eret_i | input | 1 | Check request (arms the evaluator) |
| trap_o | output | 1 | One-cycle trap request |
| isr_o | output | 32 | Latched summary mask |
| intid_o | output | 5 | Latched request level |
| ipl_o | output | 5 | Current priority level |
| sw_req_o | output | 32 | Software request register |
| ast_err_o | output | 1 | Unsupported async-trap request pending |

## Verification
Two events can fall on the same clock edge: an evaluation that disarms the evaluator, and a check request that arms it. The bench provokes this by holding `eret_i` high for two cycles while a request above the priority level stays pending. It then expects `trap_o` high for two cycles in a row, followed by a low cycle. If the disarm took precedence, only a single pulse would appear, and the bench would fail. A scoreboard compares each evaluation's trap, status and identifier against a reference that searches the request positions from the top down.

// File: rtl/irq_eval_pkg.sv
package irq_eval_pkg;

  // Contiguous bit mask covering positions lo..hi
  function automatic logic [31:0] range_mask(input int lo, input int hi);
    logic [31:0] m;
    m = '0;
    for (int i = lo; i <= hi; i++) m[i] = 1'b1;
    return m;
  endfunction

  // Software bit i maps to level (i - lo) + 1
  function automatic logic [4:0] sw_bit_level(input int idx, input int lo);
    return 5'(idx - lo + 1);
  endfunction

  // External line i maps to level i
  function automatic logic [4:0] ext_bit_level(input int idx);
    return 5'(idx);
  endfunction

  typedef enum logic [1:0] {
    SEL_IPL = 2'd0,
    SEL_SWR = 2'd1,
    SEL_AST = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_eval_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int LVL_W = 5,
  parameter int AST_W = 4,
  parameter int SW_LO = 4,
  parameter int SW_HI = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [REG_W-1:0] wdata,
  output logic [LVL_W-1:0] ipl_q,
  output logic [REG_W-1:0] sw_q,
  output logic [AST_W-1:0] ast_q
);
  localparam logic [REG_W-1:0] SW_MASK = REG_W'(range_mask(SW_LO, SW_HI));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ipl_q <= '0;
      sw_q  <= '0;
      ast_q <= '0;
    end else if (we) begin
      case (cfg_sel_e'(sel))
        SEL_IPL: ipl_q <= wdata[LVL_W-1:0];
        SEL_SWR: sw_q  <= wdata & SW_MASK;
        SEL_AST: ast_q <= wdata[AST_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_level_calc.sv
module irq_level_calc
  import irq_eval_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int LVL_W  = 5,
  parameter int SW_LO  = 4,
  parameter int SW_HI  = 18,
  parameter int EXT_LO = 20,
  parameter int EXT_HI = 30
) (
  input  logic [REG_W-1:0] sw_req,
  input  logic [REG_W-1:0] ext_req,
  output logic [LVL_W-1:0] level,
  output logic [REG_W-1:0] summary
);
  logic [REG_W-1:0] sw_hit, ext_hit;

  // Per-position qualification of each source against its range
  for (genvar g = 0; g < REG_W; g++) begin : g_qual
    if (g >= SW_LO && g <= SW_HI) begin : g_sw
      assign sw_hit[g] = sw_req[g];
    end else begin : g_sw_off
      assign sw_hit[g] = 1'b0;
    end
    if (g >= EXT_LO && g <= EXT_HI) begin : g_ext
      assign ext_hit[g] = ext_req[g];
    end else begin : g_ext_off
      assign ext_hit[g] = 1'b0;
    end
  end

  assign summary = sw_hit | ext_hit;

  // Ascending scan, software first then external: last hit wins
  always_comb begin
    level = '0;
    for (int i = SW_LO; i <= SW_HI; i++)
      if (sw_hit[i]) level = LVL_W'(sw_bit_level(i, SW_LO));
    for (int i = EXT_LO; i <= EXT_HI; i++)
      if (ext_hit[i]) level = LVL_W'(ext_bit_level(i));
  end
endmodule

// File: rtl/irq_trap_ctrl.sv
module irq_trap_ctrl #(
  parameter int REG_W = 32,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eret,
  input  logic [LVL_W-1:0] level,
  input  logic [REG_W-1:0] summary,
  input  logic [LVL_W-1:0] ipl,
  output logic             armed_q,
  output logic             take,
  output logic             trap_q,
  output logic [REG_W-1:0] isr_q,
  output logic [LVL_W-1:0] intid_q
);
  logic above;

  assign above = (level != '0) && (level > ipl);
  assign take  = armed_q && above;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      trap_q  <= 1'b0;
      isr_q   <= '0;
      intid_q <= '0;
    end else begin
      // A check request wins over the self-disarm of an evaluation
      if (eret)         armed_q <= 1'b1;
      else if (armed_q) armed_q <= 1'b0;
      trap_q <= take;
      if (take) begin
        isr_q   <= summary;
        intid_q <= level;
      end
    end
  end
endmodule

// File: rtl/irq_level_eval.sv
module irq_level_eval #(
  parameter int REG_W  = 32,
  parameter int LVL_W  = 5,
  parameter int AST_W  = 4,
  parameter int SW_LO  = 4,
  parameter int SW_HI  = 18,
  parameter int EXT_LO = 20,
  parameter int EXT_HI = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic [REG_W-1:0] ext_irq,
  input  logic             eret_i,
  output logic             trap_o,
  output logic [REG_W-1:0] isr_o,
  output logic [LVL_W-1:0] intid_o,
  output logic [LVL_W-1:0] ipl_o,
  output logic [REG_W-1:0] sw_req_o,
  output logic             ast_err_o
);
  logic [AST_W-1:0] ast_w;
  logic [LVL_W-1:0] lvl_w;
  logic [REG_W-1:0] sum_w;
  logic             armed_w;
  logic             take_w;

  irq_cfg_regs #(
    .REG_W(REG_W), .LVL_W(LVL_W), .AST_W(AST_W), .SW_LO(SW_LO), .SW_HI(SW_HI)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .ipl_q(ipl_o), .sw_q(sw_req_o), .ast_q(ast_w)
  );

  irq_level_calc #(
    .REG_W(REG_W), .LVL_W(LVL_W), .SW_LO(SW_LO), .SW_HI(SW_HI),
    .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)
  ) u_calc (
    .sw_req(sw_req_o), .ext_req(ext_irq), .level(lvl_w), .summary(sum_w)
  );

  irq_trap_ctrl #(.REG_W(REG_W), .LVL_W(LVL_W)) u_trap (
    .clk(clk), .rst_n(rst_n), .eret(eret_i), .level(lvl_w), .summary(sum_w),
    .ipl(ipl_o), .armed_q(armed_w), .take(take_w), .trap_q(trap_o),
    .isr_q(isr_o), .intid_q(intid_o)
  );

  assign ast_err_o = (ast_w != '0);
endmodule

// File: rtl/irq_level_eval_chk.sv
module irq_level_eval_chk #(
  parameter int REG_W = 32,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [1:0]       cfg_sel,
  input logic [REG_W-1:0] cfg_wdata,
  input logic             eret_i,
  input logic             trap_o,
  input logic [REG_W-1:0] isr_o,
  input logic [LVL_W-1:0] intid_o,
  input logic [LVL_W-1:0] ipl_o,
  input logic             ast_err_o,
  input logic             armed_w,
  input logic             take_w
);
  a_r5_trap_above_ipl: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (intid_o != '0) && (intid_o > $past(ipl_o)));

  a_r6_trap_after_armed: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $past(armed_w));

  a_r6_hold_status: assert property (@(posedge clk) disable iff (!rst_n)
    !take_w |=> $stable(isr_o) && $stable(intid_o));

  a_r9_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    armed_w && !eret_i |=> !armed_w);

  a_r9_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    eret_i |=> armed_w);

  a_r10_ast_err: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_sel == 2'd2 && cfg_wdata[3:0] != 4'h0 |=> ast_err_o);
endmodule

bind irq_level_eval irq_level_eval_chk #(.REG_W(REG_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .eret_i(eret_i), .trap_o(trap_o), .isr_o(isr_o),
  .intid_o(intid_o), .ipl_o(ipl_o), .ast_err_o(ast_err_o),
  .armed_w(armed_w), .take_w(take_w)
);

// File: tb/tb_irq_level_eval.sv
module tb_irq_level_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd3;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] ext_irq = '0;
  logic        eret_i = 1'b0;
  logic        trap_o;
  logic [31:0] isr_o;
  logic [4:0]  intid_o;
  logic [4:0]  ipl_o;
  logic [31:0] sw_req_o;
  logic        ast_err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_level_eval dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ext_irq(ext_irq), .eret_i(eret_i),
    .trap_o(trap_o), .isr_o(isr_o), .intid_o(intid_o), .ipl_o(ipl_o),
    .sw_req_o(sw_req_o), .ast_err_o(ast_err_o)
  );

  typedef struct {
    logic        trap;
    logic [31:0] isr;
    logic [4:0]  id;
    string       req;
  } exp_t;

  exp_t  sb[$];
  event  ev_sample;
  logic [31:0] m_isr = '0;
  logic [4:0]  m_id  = '0;
  logic [4:0]  m_ipl = '0;
  logic [31:0] m_sw  = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Reference level: search downward, external range before software
  function automatic logic [4:0] ref_level(input logic [31:0] sw, input logic [31:0] ext);
    for (int i = 30; i >= 20; i--) if (ext[i]) return 5'(i);
    for (int i = 18; i >= 4; i--)  if (sw[i])  return 5'(i - 3);
    return 5'd0;
  endfunction

  // Monitor: pop one expected result per evaluation and compare
  initial begin
    forever begin
      @(ev_sample);
      if (sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        check({e.req, " trap"}, {31'd0, trap_o}, {31'd0, e.trap});
        check({e.req, " isr"}, isr_o, e.isr);
        check({e.req, " intid"}, {27'd0, intid_o}, {27'd0, e.id});
      end
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'd3;
    if (sel == 2'd0) m_ipl = d[4:0];
    if (sel == 2'd1) m_sw = d & 32'h0007FFF0;
  endtask

  // Driver: one armed evaluation, expectation pushed for the monitor
  task automatic evaluate(input logic [31:0] ext, input string req);
    exp_t e;
    logic [4:0] lv;
    @(negedge clk);
    ext_irq = ext; eret_i = 1'b1;
    @(negedge clk);
    eret_i = 1'b0;
    @(negedge clk);
    lv = ref_level(m_sw, ext);
    e.trap = (lv != 0) && (lv > m_ipl);
    if (e.trap) begin
      m_isr = (m_sw & 32'h0007FFF0) | (ext & 32'h7FF00000);
      m_id  = lv;
    end
    e.isr = m_isr; e.id = m_id; e.req = req;
    sb.push_back(e);
    ->ev_sample;
    #1;
    @(negedge clk);
    check({req, " R6 pulse ends"}, {31'd0, trap_o}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // Reset state (the post-reset evaluation sees no request)
    check("reset trap", {31'd0, trap_o}, 32'd0);
    check("reset isr", isr_o, 32'd0);
    check("reset intid", {27'd0, intid_o}, 32'd0);
    check("reset R7 ipl", {27'd0, ipl_o}, 32'd0);
    check("reset R8 sw", sw_req_o, 32'd0);
    check("reset R10 ast", {31'd0, ast_err_o}, 32'd0);

    // R8: software request write masking
    cfg_write(2'd1, 32'hFFFF_FFFF);
    check("R8 sw mask", sw_req_o, 32'h0007FFF0);
    // R7: priority level write masking
    cfg_write(2'd0, 32'h0000_00FF);
    check("R7 ipl mask", {27'd0, ipl_o}, 32'h1F);
    cfg_write(2'd0, 32'h0);
    // R7/R8: select 3 writes nothing
    cfg_write(2'd3, 32'h0000_0007);
    check("R7 sel3 ignored", {27'd0, ipl_o}, 32'd0);
    check("R8 sel3 ignored", sw_req_o, 32'h0007FFF0);

    // R10: async-trap register masking and error flag
    cfg_write(2'd2, 32'h0000_0010);
    check("R10 ast upper bits dropped", {31'd0, ast_err_o}, 32'd0);
    cfg_write(2'd2, 32'h0000_0003);
    check("R10 ast nonzero", {31'd0, ast_err_o}, 32'd1);
    cfg_write(2'd2, 32'h0);
    check("R10 ast cleared", {31'd0, ast_err_o}, 32'd0);

    // R1: lowest and highest software positions
    cfg_write(2'd1, 32'h0000_0010);
    evaluate(32'h0, "R1 sw bit4 level1");
    cfg_write(2'd1, 32'h0004_0000);
    evaluate(32'h0, "R1 sw bit18 level15");
    // R2, R3, R4: external outranks software, summary merges both
    cfg_write(2'd1, 32'h0000_0120);
    evaluate(32'h0200_0000, "R2 R3 R4 ext25 with sw");
    cfg_write(2'd1, 32'h0);
    evaluate(32'h4010_0000, "R2 R4 ext20 and ext30");
    // R4, R6: out-of-range lines only, no trap, status holds
    evaluate(32'h800F_FFFF, "R4 R6 out of range ignored");

    // R5: equal level blocked, one below passes
    cfg_write(2'd0, 32'd25);
    evaluate(32'h0200_0000, "R5 level equal ipl");
    cfg_write(2'd0, 32'd24);
    evaluate(32'h0200_0000, "R5 level above ipl");

    // R9: without a check request nothing is evaluated
    cfg_write(2'd0, 32'd0);
    @(negedge clk);
    ext_irq = 32'h4000_0000;
    repeat (3) @(negedge clk);
    check("R9 unarmed no trap", {31'd0, trap_o}, 32'd0);
    check("R9 unarmed isr held", isr_o, m_isr);

    // R9: check request on the evaluating edge keeps the evaluator armed
    @(negedge clk);
    eret_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    eret_i = 1'b0;
    check("R9 same-edge first trap", {31'd0, trap_o}, 32'd1);
    check("R9 same-edge intid", {27'd0, intid_o}, 32'd30);
    @(negedge clk);
    check("R9 same-edge second trap", {31'd0, trap_o}, 32'd1);
    @(negedge clk);
    check("R9 R6 trap ends", {31'd0, trap_o}, 32'd0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule